// File: doc/BRIEF.md
# Packed Integer Lane ALU

This block is a single-cycle packed integer unit. It receives two 64-bit operands and applies one operation to every lane of the word simultaneously. The caller picks the lane width per operation: eight 8-bit lanes, four 16-bit lanes, or two 32-bit lanes. Add and subtract each come in three variants. The wrapping variant discards the carry. The signed variant clamps to the lane's two's-complement range. The unsigned variant clamps to zero and to all ones.

Compares produce lane masks rather than flags. A lane is all ones when its condition holds and all zeros when it does not, so the result can drive a later select. Four bitwise operations work on the whole word and ignore the lane width.

A single 64-bit adder serves add, subtract and compare. It is broken into independent lanes by gating the carry at every lane boundary. The result is captured in an output register together with a valid bit. No condition flags exist.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals `in_valid` from one clock earlier. `result` loads only on a clock where `in_valid` is 1 and otherwise holds its value.
- R3: Opcode 0 (add) and opcode 3 (subtract, `opa - opb`) wrap modulo the lane width. No carry or borrow crosses a lane boundary.
- R4: Opcodes 1 (add) and 4 (subtract) saturate signed. A lane whose true result exceeds the maximum of its width gives 0x7F, 0x7FFF or 0x7FFFFFFF. A lane below the minimum gives 0x80, 0x8000 or 0x80000000.
- R5: Opcodes 2 (add) and 5 (subtract) saturate unsigned. Lanes that overflow give all ones, and lanes that underflow give zero.
- R6: Opcode 6 writes all ones to each lane where `opa` equals `opb` and all zeros to each lane where they differ.
- R7: Opcode 7 writes all ones to each lane where `opa` is greater than `opb` as signed values, and all zeros otherwise.
- R8: Opcodes 8, 9, 10 and 11 give `opa & opb`, `~opa & opb`, `opa | opb` and `opa ^ opb` over all 64 bits, whatever the lane width.
- R9: `lane_sz` selects the lane width: 0 means 8-bit lanes, 1 means 16-bit lanes, and 2 or 3 mean 32-bit lanes. Lane k occupies bits starting at k times the width.
- R10: Opcodes 12 to 15 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 4 | Operation code |
| lane_sz | input | 2 | Lane width select |
| opa | input | 64 | First (destination) operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
Every opcode is run against every lane width using pseudo-random operands. The bench compares against a lane-by-lane integer model that knows nothing of byte carries.

Directed vectors place all-ones next to a carry-in. This shows whether a carry leaks into the neighbouring lane, which separates correct lane splitting from one that is wrong by one width. Other directed vectors sit at 0x7F, 0x80, 0xFF and zero. These separate signed from unsigned clamping and overflow from underflow. They also catch a compare that treats 0x80 as large.

Idle cycles are interleaved with the vectors to show that the result holds while no input is valid.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDS  = 4'd1,
        OP_ADDUS = 4'd2,
        OP_SUB   = 4'd3,
        OP_SUBS  = 4'd4,
        OP_SUBUS = 4'd5,
        OP_CEQ   = 4'd6,
        OP_CGT   = 4'd7,
        OP_AND   = 4'd8,
        OP_ANDN  = 4'd9,
        OP_OR    = 4'd10,
        OP_XOR   = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_SGN  = 2'd1,
        SAT_UNS  = 2'd2
    } sat_e;

    // Highest byte index within a lane, as a mask: 8b->0, 16b->1, 32b->3
    function automatic logic [1:0] lane_byte_mask(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic [NB*BYTE_W-1:0] a,
    input  logic [NB*BYTE_W-1:0] b,
    input  logic                 sub,
    input  logic [1:0]           lmask,
    output logic [NB*BYTE_W-1:0] bx,
    output logic [NB*BYTE_W-1:0] sum,
    output logic [NB-1:0]        cout
);
    always_comb begin
        logic          c;
        logic [BYTE_W:0] t;
        c    = 1'b0;
        t    = '0;
        bx   = '0;
        sum  = '0;
        cout = '0;
        for (int i = 0; i < NB; i++) begin
            bx[i*BYTE_W +: BYTE_W] = b[i*BYTE_W +: BYTE_W] ^ {BYTE_W{sub}};
            // a lane starts where the low index bits under the mask are zero
            if ((i & int'(lmask)) == 0) c = sub;
            t = {1'b0, a[i*BYTE_W +: BYTE_W]} + {1'b0, bx[i*BYTE_W +: BYTE_W]}
                + {{BYTE_W{1'b0}}, c};
            sum[i*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
            cout[i] = t[BYTE_W];
            c = t[BYTE_W];
        end
    end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat
    import simd_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic [NB*BYTE_W-1:0] a,
    input  logic [NB*BYTE_W-1:0] bx,
    input  logic [NB*BYTE_W-1:0] sum,
    input  logic [NB-1:0]        cout,
    input  logic                 sub,
    input  logic [1:0]           lmask,
    input  sat_e                 mode,
    output logic [NB*BYTE_W-1:0] y
);
    localparam logic [BYTE_W-1:0] ALL1 = '1;
    localparam logic [BYTE_W-1:0] TOPMAX = {1'b0, {(BYTE_W-1){1'b1}}};
    localparam logic [BYTE_W-1:0] TOPMIN = {1'b1, {(BYTE_W-1){1'b0}}};

    always_comb begin
        int   top;
        logic sa, sb, ss, ovf_s, ovf_u;
        top = 0;
        sa = 1'b0; sb = 1'b0; ss = 1'b0; ovf_s = 1'b0; ovf_u = 1'b0;
        y = sum;
        for (int i = 0; i < NB; i++) begin
            top   = i | int'(lmask);
            sa    = a[top*BYTE_W + BYTE_W-1];
            sb    = bx[top*BYTE_W + BYTE_W-1];
            ss    = sum[top*BYTE_W + BYTE_W-1];
            ovf_s = (sa == sb) && (ss != sa);
            ovf_u = sub ? ~cout[top] : cout[top];
            unique case (mode)
                SAT_UNS: if (ovf_u)
                    y[i*BYTE_W +: BYTE_W] = sub ? '0 : ALL1;
                SAT_SGN: if (ovf_s) begin
                    if (sa) y[i*BYTE_W +: BYTE_W] = (i == top) ? TOPMIN : '0;
                    else    y[i*BYTE_W +: BYTE_W] = (i == top) ? TOPMAX : ALL1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
    import simd_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic [NB*BYTE_W-1:0] a,
    input  logic [NB*BYTE_W-1:0] b,
    input  logic [NB*BYTE_W-1:0] bx,
    input  logic [NB*BYTE_W-1:0] sum,
    input  logic [1:0]           lmask,
    input  logic                 is_gt,
    output logic [NB*BYTE_W-1:0] y
);
    logic [NB-1:0] eqb;

    generate
        for (genvar g = 0; g < NB; g++) begin : g_eq
            assign eqb[g] = (a[g*BYTE_W +: BYTE_W] == b[g*BYTE_W +: BYTE_W]);
        end
    endgenerate

    always_comb begin
        int   top;
        logic eq, lt, n, v;
        top = 0; eq = 1'b0; lt = 1'b0; n = 1'b0; v = 1'b0;
        y = '0;
        for (int i = 0; i < NB; i++) begin
            top = i | int'(lmask);
            eq  = 1'b1;
            for (int j = 0; j < NB; j++)
                if ((j | int'(lmask)) == top) eq = eq & eqb[j];
            // signed a < b from a - b: sign xor overflow at the lane's top byte
            n  = sum[top*BYTE_W + BYTE_W-1];
            v  = (a[top*BYTE_W + BYTE_W-1] == bx[top*BYTE_W + BYTE_W-1]) &&
                 (n != a[top*BYTE_W + BYTE_W-1]);
            lt = n ^ v;
            if (is_gt ? (!lt && !eq) : eq) y[i*BYTE_W +: BYTE_W] = '1;
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        lane_sz,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int NB = DATA_W / BYTE_W;

    logic              sub;
    logic [1:0]        lmask;
    sat_e              mode;
    logic [DATA_W-1:0] bx, sum, sat_y, cmp_y;
    logic [NB-1:0]     cout;
    logic [DATA_W-1:0] res_d, res_q;
    logic              vld_q;

    always_comb begin
        lmask = lane_byte_mask(lane_sz);
        sub   = (op == OP_SUB) || (op == OP_SUBS) || (op == OP_SUBUS) || (op == OP_CGT);
        if ((op == OP_ADDS) || (op == OP_SUBS))        mode = SAT_SGN;
        else if ((op == OP_ADDUS) || (op == OP_SUBUS)) mode = SAT_UNS;
        else                                           mode = SAT_NONE;
    end

    simd_lane_adder #(.NB(NB)) u_add (
        .a(opa), .b(opb), .sub(sub), .lmask(lmask),
        .bx(bx), .sum(sum), .cout(cout)
    );

    simd_lane_sat #(.NB(NB)) u_sat (
        .a(opa), .bx(bx), .sum(sum), .cout(cout), .sub(sub),
        .lmask(lmask), .mode(mode), .y(sat_y)
    );

    simd_lane_cmp #(.NB(NB)) u_cmp (
        .a(opa), .b(opb), .bx(bx), .sum(sum), .lmask(lmask),
        .is_gt(op == OP_CGT), .y(cmp_y)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDS, OP_ADDUS,
            OP_SUB, OP_SUBS, OP_SUBUS: res_d = sat_y;
            OP_CEQ, OP_CGT:            res_d = cmp_y;
            OP_AND:                    res_d = opa & opb;
            OP_ANDN:                   res_d = ~opa & opb;
            OP_OR:                     res_d = opa | opb;
            OP_XOR:                    res_d = opa ^ opb;
            default:                   res_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [1:0]  lane_sz,
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic        out_valid,
    input logic [63:0] result
);
    logic ok16;
    always_comb begin
        ok16 = 1'b1;
        for (int k = 0; k < 4; k++)
            if ((result[k*16 +: 16] != 16'h0000) && (result[k*16 +: 16] != 16'hFFFF))
                ok16 = 1'b0;
    end

    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    a_r6_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd6 && lane_sz == 2'd1) |=> ok16);
    a_r8_xor_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd11) |=> (result == $past(opa ^ opb)));
    a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd12) |=> (result == 64'd0));
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && result == 64'd0));
endmodule

bind simd_alu simd_alu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
);

// File: tb/simd_alu_tb.sv
module simd_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  lane_sz = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        out_valid;
    logic [63:0] result;

    int          n_cmp = 0, n_bad = 0;
    logic        exp_v = 1'b0;
    logic [63:0] exp_r = '0;
    string       cur_tag = "R1";
    logic [63:0] seed = 64'h9E3779B97F4A7C15;

    always #10 clk = ~clk;

    simd_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    function automatic longint clampl(input longint x, input longint lo, input longint hi);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic logic [63:0] model(input logic [3:0] o, input logic [1:0] s,
                                          input logic [63:0] a, input logic [63:0] b);
        int w, n;
        longint m, ua, ub, sa, sb, r, smin, smax;
        logic [63:0] res;
        case (o)
            4'd8:  return a & b;
            4'd9:  return ~a & b;
            4'd10: return a | b;
            4'd11: return a ^ b;
            4'd12, 4'd13, 4'd14, 4'd15: return 64'd0;
            default: ;
        endcase
        w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        n = 64 / w;
        m = (64'sd1 <<< w) - 1;
        smax = (64'sd1 <<< (w-1)) - 1;
        smin = -(64'sd1 <<< (w-1));
        res = '0;
        for (int k = 0; k < n; k++) begin
            ua = longint'((a >> (k*w))) & m;
            ub = longint'((b >> (k*w))) & m;
            sa = (ua > smax) ? ua - (m + 1) : ua;
            sb = (ub > smax) ? ub - (m + 1) : ub;
            case (o)
                4'd0: r = ua + ub;
                4'd1: r = clampl(sa + sb, smin, smax);
                4'd2: r = clampl(ua + ub, 0, m);
                4'd3: r = ua - ub;
                4'd4: r = clampl(sa - sb, smin, smax);
                4'd5: r = clampl(ua - ub, 0, m);
                4'd6: r = (ua == ub) ? m : 0;
                default: r = (sa > sb) ? m : 0;
            endcase
            res = res | (64'(r & m) << (k*w));
        end
        return res;
    endfunction

    task automatic check();
        n_cmp++;
        if (out_valid !== exp_v || result !== exp_r) begin
            n_bad++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     cur_tag, out_valid, result, exp_v, exp_r);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] o, input logic [1:0] s,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        check();
        in_valid = v; op = o; lane_sz = s; opa = a; opb = b;
        if (v) exp_r = model(o, s, a, b);
        exp_v = v;
        cur_tag = tag;
    endtask

    function automatic string tag_of(input logic [3:0] o, input logic [1:0] s);
        if (s == 2'd3 && o < 4'd8) return "R9";
        case (o)
            4'd0, 4'd3: return "R3";
            4'd1, 4'd4: return "R4";
            4'd2, 4'd5: return "R5";
            4'd6:       return "R6";
            4'd7:       return "R7";
            4'd8, 4'd9, 4'd10, 4'd11: return "R8";
            default:    return "R10";
        endcase
    endfunction

    function automatic logic [63:0] nxt(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    initial begin
        logic [63:0] ra, rb;
        // R1: reset state observed while reset is held
        @(negedge clk); check();
        @(negedge clk); check();
        rst_n = 1'b1;

        // R3: carry must stop at each lane boundary
        step(1, 4'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R3");
        step(1, 4'd0, 2'd1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, "R3");
        step(1, 4'd3, 2'd2, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, "R3");
        // R4: signed clamps, both ends
        step(1, 4'd1, 2'd0, 64'h7F7F_8080_7F00_8000, 64'h0101_FFFF_7F00_8000, "R4");
        step(1, 4'd4, 2'd1, 64'h8000_7FFF_0000_1234, 64'h0001_FFFF_8000_1234, "R4");
        step(1, 4'd1, 2'd2, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, "R4");
        // R5: unsigned clamps, both ends
        step(1, 4'd2, 2'd0, 64'hFFFF_0102_80FE_0000, 64'h0101_FFFF_8002_0000, "R5");
        step(1, 4'd5, 2'd1, 64'h0000_0005_FFFF_0001, 64'h0001_0006_0001_0002, "R5");
        // R6 / R7 masks, including 0x80 vs 0x7F
        step(1, 4'd6, 2'd1, 64'h1234_5678_0000_FFFF, 64'h1234_5679_0000_FFFE, "R6");
        step(1, 4'd7, 2'd0, 64'h807F_0001_FF00_7F80, 64'h7F80_0100_00FF_807F, "R7");
        step(1, 4'd7, 2'd2, 64'h8000_0000_0000_0002, 64'h7FFF_FFFF_0000_0001, "R7");
        // R8: destination-inverting AND, independent of lane width
        step(1, 4'd9, 2'd1, 64'hF0F0_F0F0_0000_FFFF, 64'hFFFF_0000_1234_5678, "R8");
        // R2: idle cycles hold the last result
        step(0, 4'd0, 2'd0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1, "R2");
        step(0, 4'd11, 2'd2, 64'h1, 64'h2, "R2");
        // R10 / R9 directed
        step(1, 4'd13, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R10");
        step(1, 4'd0, 2'd3, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R9");

        for (int o = 0; o < 16; o++) begin
            for (int s = 0; s < 4; s++) begin
                for (int r = 0; r < 20; r++) begin
                    seed = nxt(seed); ra = seed;
                    seed = nxt(seed); rb = seed;
                    if (r % 5 == 0) rb = ra;               // equal lanes for compares
                    if (r % 7 == 3) step(0, 4'(o), 2'(s), rb, ra, "R2");
                    step(1, 4'(o), 2'(s), ra, rb, tag_of(4'(o), 2'(s)));
                end
            end
        end
        step(0, 4'd0, 2'd0, 64'h0, 64'h0, "R2");
        @(negedge clk); check();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: valid=%0b result=%h expected run to complete", out_valid, result);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule